// File: doc/BRIEF.md
# Two-Wire Bus Condition Monitor

This block listens to the clock and data lines of an open-drain two-wire serial bus, such as I2C, without ever driving them. Each line is formed from several open-drain driver outputs by wired-AND resolution. The resolved line is then brought into the system clock domain through a synchronizer chain and cleaned up by a glitch filter. Line transitions are judged on the filtered levels against the previous filtered sample.

The monitor reports three bus conditions, each as a one-cycle pulse: a first START, a REPEATED START and a STOP. It also holds a bus-busy level. While the clock is high it samples data bits most significant first, and after the eighth bit it strobes out the assembled byte. The ninth clock pulse is the acknowledge slot, which is counted but not stored. When both lines change in the same sample while the clock is high, the monitor reports a framing violation and no condition.

It serves as a passive observer for protocol checkers, bus analysers or a slave front end that needs a clean view of bus framing. The bus addresses it observes are 7 bits wide, but address decoding is left to later logic.

Top module: `twoWireCondMonitor`

## Requirements
- R1: Each line resolves low while any of its `NUM_DRV` driver bits is 0 and resolves high only when all its driver bits are 1. A STOP is not seen until the last driver holding data low lets go.
- R2: A data fall while the clock is high, with the bus not busy, gives one `startPulse` cycle, and `busBusy` rises in the same cycle.
- R3: A data fall while the clock is high, with the bus already busy, gives `restartPulse` instead of `startPulse`, and `busBusy` stays 1.
- R4: A data rise while the clock is high gives one `stopPulse` cycle and leaves `busBusy` at 0. This holds even when the bus was idle.
- R5: On each rising clock edge the data level is shifted in most significant bit first. When the eighth bit arrives, `byteReady` pulses for one cycle, `rxByte` takes the byte, and `bitCount` reads 8.
- R6: The ninth rising clock edge moves `bitCount` to 9 and leaves `rxByte` unchanged, with no `byteReady`. The next rising edge begins a new byte with `bitCount` at 1.
- R7: Any START, REPEATED START or STOP returns `bitCount` to 0.
- R8: A line pulse shorter than `FILT_LEN` system cycles has no effect on any output.
- R9: When both filtered lines change in the same cycle and the clock is high before or after that change, the monitor pulses `violation` and reports no condition.
- R10: After synchronous reset, `busBusy`, `bitCount`, `rxByte` and every pulse output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclDrv | input | NUM_DRV | Open-drain clock driver outputs, 0 pulls the line low |
| sdaDrv | input | NUM_DRV | Open-drain data driver outputs, 0 pulls the line low |
| startPulse | output | 1 | START seen on an idle bus |
| restartPulse | output | 1 | START seen on a busy bus |
| stopPulse | output | 1 | STOP seen |
| violation | output | 1 | Both lines changed together while the clock was high |
| busBusy | output | 1 | Bus held between START and STOP |
| bitCount | output | 4 | Clock pulses since the last condition or byte, 0 to 9 |
| byteReady | output | 1 | One-cycle strobe when a byte is complete |
| rxByte | output | 8 | Last completed byte |

## Verification
Two situations are the hardest to reach from the ports. The first is a STOP that must stay hidden because a second driver still holds data low. The bench drives both drivers low, releases them one at a time while the clock is high, and checks that the STOP pulse appears only after the second release. The second is a violation, which needs both filtered lines to change in the same cycle. The bench gets there by changing both driver inputs on the same clock edge, since both lines pass through identical synchronizer and filter pipelines. The acknowledge slot is reached by sending a full byte followed by a ninth clock pulse, and then a second byte to show that counting restarts at 1.

// File: rtl/twcPkg.sv
package twcPkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;
  localparam int ACK_SLOT = BYTE_W + 1;

  typedef struct packed {
    logic shiftBit;    // rising clock edge: sample data
    logic clearCount;  // any bus condition: restart framing
  } twcStrobes_t;
endpackage

// File: rtl/twcLineConditioner.sv
module twcLineConditioner #(
  parameter int NUM_DRV     = 2,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_DRV-1:0] drv,
  output logic               lineOut
);
  localparam int FCNT_W = $clog2(FILT_LEN + 1);

  logic resolved;
  logic [SYNC_STAGES-1:0] syncQ;
  logic [FCNT_W-1:0] stableCnt;

  // wired-AND: any driver at 0 pulls the line low
  assign resolved = &drv;

  always_ff @(posedge clk) begin
    if (rst) syncQ <= '1;
    else     syncQ <= {syncQ[SYNC_STAGES-2:0], resolved};
  end

  // accept a new level only after FILT_LEN consecutive differing samples
  always_ff @(posedge clk) begin
    if (rst) begin
      lineOut   <= 1'b1;
      stableCnt <= '0;
    end else if (syncQ[SYNC_STAGES-1] == lineOut) begin
      stableCnt <= '0;
    end else if (stableCnt == FCNT_W'(FILT_LEN - 1)) begin
      lineOut   <= syncQ[SYNC_STAGES-1];
      stableCnt <= '0;
    end else begin
      stableCnt <= stableCnt + 1'b1;
    end
  end
endmodule

// File: rtl/twcControl.sv
module twcControl
  import twcPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        sclLine,
  input  logic        sdaLine,
  output twcStrobes_t strobes,
  output logic        startPulse,
  output logic        restartPulse,
  output logic        stopPulse,
  output logic        violation,
  output logic        busBusy
);
  logic sclPrev, sdaPrev;
  logic sclChange, sdaChange, sclHighBoth;
  logic startCond, stopCond, badChange;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclLine;
      sdaPrev <= sdaLine;
    end
  end

  assign sclChange   = sclPrev ^ sclLine;
  assign sdaChange   = sdaPrev ^ sdaLine;
  assign sclHighBoth = sclPrev & sclLine;
  assign startCond   = sclHighBoth & sdaPrev & ~sdaLine;
  assign stopCond    = sclHighBoth & ~sdaPrev & sdaLine;
  assign badChange   = sclChange & sdaChange & (sclPrev | sclLine);

  always_comb begin
    strobes.shiftBit   = ~sclPrev & sclLine & ~sdaChange;
    strobes.clearCount = startCond | stopCond;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      startPulse   <= 1'b0;
      restartPulse <= 1'b0;
      stopPulse    <= 1'b0;
      violation    <= 1'b0;
      busBusy      <= 1'b0;
    end else begin
      startPulse   <= startCond & ~busBusy;
      restartPulse <= startCond & busBusy;
      stopPulse    <= stopCond;
      violation    <= badChange;
      if (stopCond)       busBusy <= 1'b0;
      else if (startCond) busBusy <= 1'b1;
    end
  end
endmodule

// File: rtl/twcDatapath.sv
module twcDatapath
  import twcPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  twcStrobes_t       strobes,
  input  logic              sdaLine,
  output logic [CNT_W-1:0]  bitCount,
  output logic              byteReady,
  output logic [BYTE_W-1:0] rxByte
);
  logic [BYTE_W-1:0] shiftReg;
  logic [BYTE_W-1:0] nextShift;

  assign nextShift = {shiftReg[BYTE_W-2:0], sdaLine};

  always_ff @(posedge clk) begin
    if (rst) begin
      bitCount  <= '0;
      shiftReg  <= '0;
      rxByte    <= '0;
      byteReady <= 1'b0;
    end else begin
      byteReady <= 1'b0;
      if (strobes.clearCount) begin
        bitCount <= '0;
      end else if (strobes.shiftBit) begin
        if (bitCount == CNT_W'(BYTE_W)) begin
          bitCount <= CNT_W'(ACK_SLOT);       // acknowledge slot, no shift
        end else begin
          shiftReg <= nextShift;
          if (bitCount == CNT_W'(BYTE_W - 1)) begin
            rxByte    <= nextShift;
            byteReady <= 1'b1;
            bitCount  <= CNT_W'(BYTE_W);
          end else if (bitCount == CNT_W'(ACK_SLOT)) begin
            bitCount <= CNT_W'(1);
          end else begin
            bitCount <= bitCount + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/twoWireCondMonitor.sv
module twoWireCondMonitor
  import twcPkg::*;
#(
  parameter int NUM_DRV     = 2,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_DRV-1:0] sclDrv,
  input  logic [NUM_DRV-1:0] sdaDrv,
  output logic               startPulse,
  output logic               restartPulse,
  output logic               stopPulse,
  output logic               violation,
  output logic               busBusy,
  output logic [3:0]         bitCount,
  output logic               byteReady,
  output logic [7:0]         rxByte
);
  logic sclLine, sdaLine;
  twcStrobes_t strobes;

  twcLineConditioner #(.NUM_DRV(NUM_DRV), .SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN))
    u_sclCond (.clk(clk), .rst(rst), .drv(sclDrv), .lineOut(sclLine));

  twcLineConditioner #(.NUM_DRV(NUM_DRV), .SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN))
    u_sdaCond (.clk(clk), .rst(rst), .drv(sdaDrv), .lineOut(sdaLine));

  twcControl u_ctrl (
    .clk(clk), .rst(rst), .sclLine(sclLine), .sdaLine(sdaLine),
    .strobes(strobes), .startPulse(startPulse), .restartPulse(restartPulse),
    .stopPulse(stopPulse), .violation(violation), .busBusy(busBusy)
  );

  twcDatapath u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .sdaLine(sdaLine),
    .bitCount(bitCount), .byteReady(byteReady), .rxByte(rxByte)
  );
endmodule

// File: rtl/twcMonitorChecker.sv
module twcMonitorChecker (
  input logic       clk,
  input logic       rst,
  input logic       startPulse,
  input logic       restartPulse,
  input logic       stopPulse,
  input logic       violation,
  input logic       busBusy,
  input logic [3:0] bitCount,
  input logic       byteReady,
  input logic [7:0] rxByte
);
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({startPulse, restartPulse, stopPulse, violation})); // R9
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    startPulse |-> busBusy); // R2
  AST_BUSY_ONLY_BY_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busBusy) |-> startPulse); // R2
  AST_RESTART_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    restartPulse |-> busBusy && $past(busBusy)); // R3
  AST_STOP_CLEARS_BUSY: assert property (@(posedge clk) disable iff (rst)
    stopPulse |-> !busBusy); // R4
  AST_COND_CLEARS_COUNT: assert property (@(posedge clk) disable iff (rst)
    (startPulse || restartPulse || stopPulse) |-> bitCount == 4'd0); // R7
  AST_BYTE_AT_EIGHT: assert property (@(posedge clk) disable iff (rst)
    byteReady |-> bitCount == 4'd8); // R5
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    bitCount <= 4'd9); // R6
  AST_ACK_KEEPS_BYTE: assert property (@(posedge clk) disable iff (rst)
    (bitCount == 4'd9) |-> $stable(rxByte) && !byteReady); // R6
endmodule

bind twoWireCondMonitor twcMonitorChecker u_chk (.*);

// File: tb/tb_twoWireCondMonitor.sv
module tb_twoWireCondMonitor;
  localparam int NUM_DRV = 2;
  localparam int HOLD = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NUM_DRV-1:0] sclDrv = '1;
  logic [NUM_DRV-1:0] sdaDrv = '1;
  logic startPulse, restartPulse, stopPulse, violation, busBusy, byteReady;
  logic [3:0] bitCount;
  logic [7:0] rxByte;

  int errors = 0;
  int checks = 0;
  int startCnt = 0, restartCnt = 0, stopCnt = 0, violCnt = 0, byteCnt = 0;
  logic [7:0] lastByte = '0;
  int s0, r0, p0, v0, b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  twoWireCondMonitor #(.NUM_DRV(NUM_DRV), .SYNC_STAGES(2), .FILT_LEN(3)) dut (
    .clk(clk), .rst(rst), .sclDrv(sclDrv), .sdaDrv(sdaDrv),
    .startPulse(startPulse), .restartPulse(restartPulse), .stopPulse(stopPulse),
    .violation(violation), .busBusy(busBusy), .bitCount(bitCount),
    .byteReady(byteReady), .rxByte(rxByte)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (startPulse)   startCnt++;
      if (restartPulse) restartCnt++;
      if (stopPulse)    stopCnt++;
      if (violation)    violCnt++;
      if (byteReady) begin byteCnt++; lastByte = rxByte; end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic snap();
    s0 = startCnt; r0 = restartCnt; p0 = stopCnt; v0 = violCnt; b0 = byteCnt;
  endtask

  task automatic waitHold();
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic setLines(input logic scl, input logic sda);
    @(negedge clk);
    sclDrv[0] = scl;
    sdaDrv[0] = sda;
    waitHold();
  endtask

  task automatic busStart();
    setLines(1'b0, 1'b1);
    setLines(1'b1, 1'b1);
    setLines(1'b1, 1'b0);
    setLines(1'b0, 1'b0);
  endtask

  task automatic sendBit(input logic b);
    setLines(1'b0, b);
    setLines(1'b1, b);
    setLines(1'b0, b);
  endtask

  task automatic sendByte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
  endtask

  task automatic busStop();
    setLines(1'b0, 1'b0);
    setLines(1'b1, 1'b0);
    setLines(1'b1, 1'b1);
  endtask

  task automatic testReset();
    check("R10 busBusy", busBusy, 0);
    check("R10 bitCount", bitCount, 0);
    check("R10 rxByte", rxByte, 0);
    check("R10 pulses", {startPulse, restartPulse, stopPulse, violation, byteReady}, 0);
  endtask

  task automatic testStartAndBytes();
    snap();
    busStart();
    check("R2 startPulse count", startCnt - s0, 1);
    check("R2 no restart", restartCnt - r0, 0);
    check("R2 busBusy", busBusy, 1);
    sendByte(8'hA5);
    check("R5 byteReady count", byteCnt - b0, 1);
    check("R5 rxByte", lastByte, 8'hA5);
    check("R5 bitCount", bitCount, 8);
    sendBit(1'b0);
    check("R6 ack count", bitCount, 9);
    check("R6 rxByte kept", rxByte, 8'hA5);
    check("R6 no byteReady", byteCnt - b0, 1);
    sendBit(1'b0);
    check("R6 next byte starts at 1", bitCount, 1);
    sendByte(8'h3C);
    check("R6 second byte count", byteCnt - b0, 2);
  endtask

  task automatic testRestartAndStop();
    snap();
    busStart();
    check("R3 restartPulse count", restartCnt - r0, 1);
    check("R3 no startPulse", startCnt - s0, 0);
    check("R3 busBusy held", busBusy, 1);
    check("R7 count cleared by restart", bitCount, 0);
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1);
    check("R5 partial count", bitCount, 3);
    busStop();
    check("R4 stopPulse count", stopCnt - p0, 1);
    check("R4 busBusy cleared", busBusy, 0);
    check("R7 count cleared by stop", bitCount, 0);
  endtask

  task automatic testIdleStop();
    snap();
    setLines(1'b0, 1'b1);
    setLines(1'b0, 1'b0);
    setLines(1'b1, 1'b0);
    setLines(1'b1, 1'b1);
    check("R4 idle stop pulsed", stopCnt - p0, 1);
    check("R4 idle stop busy", busBusy, 0);
    check("R4 idle stop no start", startCnt - s0, 0);
  endtask

  task automatic testGlitch();
    snap();
    @(negedge clk); sdaDrv[0] = 1'b0;
    @(negedge clk); sdaDrv[0] = 1'b1;
    @(negedge clk); sclDrv[0] = 1'b0;
    @(negedge clk); sclDrv[0] = 1'b1;
    waitHold();
    check("R8 glitch no start", startCnt - s0, 0);
    check("R8 glitch no stop", stopCnt - p0, 0);
    check("R8 glitch busy", busBusy, 0);
    check("R8 glitch count", bitCount, 0);
  endtask

  task automatic testWiredAnd();
    busStart();
    snap();
    @(negedge clk); sdaDrv = '0;
    waitHold();
    setLines(1'b1, 1'b0);
    @(negedge clk); sdaDrv[0] = 1'b1;
    waitHold();
    check("R1 held low by other driver", stopCnt - p0, 0);
    check("R1 still busy", busBusy, 1);
    @(negedge clk); sdaDrv[1] = 1'b1;
    waitHold();
    check("R1 stop after last release", stopCnt - p0, 1);
    check("R1 busy cleared", busBusy, 0);
  endtask

  task automatic testViolation();
    snap();
    @(negedge clk); sclDrv[0] = 1'b0; sdaDrv[0] = 1'b0;
    waitHold();
    check("R9 violation on joint fall", violCnt - v0, 1);
    check("R9 no start", startCnt - s0, 0);
    @(negedge clk); sclDrv[0] = 1'b1; sdaDrv[0] = 1'b1;
    waitHold();
    check("R9 violation on joint rise", violCnt - v0, 2);
    check("R9 no stop", stopCnt - p0, 0);
    check("R9 busy", busBusy, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    testReset();
    waitHold();
    testStartAndBytes();
    testRestartAndStop();
    testIdleStop();
    testGlitch();
    testWiredAnd();
    testViolation();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule